// File: doc/BRIEF.md
# Multi-Mode Timer Counter

This block is a 16-bit timer counter advanced by the system clock through a prescaler. The prescaler can be stopped, or it can divide by 1, 8, 64, 256 or 1024. A 4-bit mode code picks the counting style and the TOP value. The style is either up-counting with a wrap to zero after TOP, or dual-slope counting, which climbs to TOP, falls back to zero and turns around again. TOP is one of five values: a fixed 0x00FF, a fixed 0x03FF, the full 0xFFFF, a compare value input, or a capture value input.

The mode code arrives in two halves, the way a pair of control registers would hold it. The block reports the count, the current direction, a one-cycle strobe on reaching TOP and a one-cycle strobe on returning to zero. It also keeps a sticky overflow flag. Software clears that flag by a write-one pulse, or it is cleared when the interrupt is serviced. The interrupt request is the flag gated by its enable.

Top module: `wave_timer16`

## Requirements
- R1: The clock-select code sets the interval between count steps. Code 3'b001 steps every cycle, 3'b010 every 8 cycles, 3'b011 every 64, 3'b100 every 256 and 3'b101 every 1024. Codes 3'b000, 3'b110 and 3'b111 stop the count, and it holds its value.
- R2: Any change of the clock-select code restarts the divider. With a new code of divisor N, the first count step lands on the N-th clock edge after the first edge that sees the new code.
- R3: The mode code is {mode_b, mode_a}. Mode 0 counts up to 0xFFFF, mode 4 up to cmp_a and mode 12 up to cap_val. Each then wraps to 0x0000 on the following step.
- R4: Mode 5 counts up to 0x00FF, mode 7 up to 0x03FF, mode 15 up to cmp_a and mode 14 up to cap_val. Each then wraps to 0x0000.
- R5: Mode 1 uses TOP 0x00FF, mode 3 uses 0x03FF, mode 11 uses cmp_a and mode 10 uses cap_val. In these modes the count climbs to TOP, then falls one per step to 0x0000, then climbs again. count_down is 1 from the step that leaves TOP through the step that reaches zero, and 0 otherwise.
- R6: top_hit is high for exactly the one cycle after the count steps onto TOP from another value.
- R7: bottom_hit is high for exactly the one cycle after the count steps onto 0x0000 from a non-zero value.
- R8: ovf_flag sets on the same edge on which the count returns to 0x0000. It stays set until an edge that sees ovf_clr or ovf_ack high. If a return to zero and a clear fall on the same edge, the flag ends up set.
- R9: ovf_irq equals ovf_flag AND ovf_ie at all times.
- R10: The unlisted mode codes 2, 6, 8, 9 and 13 behave as mode 0. They ignore cmp_a and cap_val and count up to 0xFFFF.
- R11: After reset the count is 0x0000, count_down is 0, and top_hit, bottom_hit, ovf_flag and ovf_irq are 0.
- R12: In an up mode, if the count is above a newly lowered TOP, the next step wraps the count to 0x0000. That return to zero counts as an overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_sel | input | 3 | Prescaler select code |
| mode_a | input | 2 | Mode code bits 1:0 |
| mode_b | input | 2 | Mode code bits 3:2 |
| cmp_a | input | 16 | Compare value used as TOP in modes 4, 11, 15 |
| cap_val | input | 16 | Capture value used as TOP in modes 10, 12, 14 |
| ovf_clr | input | 1 | Write-one clear of the overflow flag |
| ovf_ack | input | 1 | Interrupt-serviced clear of the overflow flag |
| ovf_ie | input | 1 | Overflow interrupt enable |
| count | output | 16 | Current count value |
| count_down | output | 1 | 1 while the count is falling in a dual-slope mode |
| top_hit | output | 1 | One-cycle strobe after the count reaches TOP |
| bottom_hit | output | 1 | One-cycle strobe after the count returns to zero |
| ovf_flag | output | 1 | Sticky overflow flag |
| ovf_irq | output | 1 | Overflow interrupt request |

## Verification
Two functions can land on the same clock edge: setting the overflow flag on a return to zero, and clearing it by software. The bench provokes this collision in mode 4 with cmp_a = 3 at divide-by-1. It counts edges so that the ovf_clr pulse covers exactly the step from 3 to 0. It then judges the result at the ports: the flag must read 1 and bottom_hit must be high. A plain clear on a non-wrapping edge, and a later service acknowledge, must each read the flag back as 0.

// File: rtl/wave_timer_pkg.sv
package wave_timer_pkg;

   typedef enum logic [2:0] {
      TOP_FULL,
      TOP_BYTE,
      TOP_TEN,
      TOP_CMP,
      TOP_CAP
   } top_src_e;

   typedef struct packed {
      logic     dual;
      top_src_e src;
   } mode_cfg_t;

   function automatic mode_cfg_t decode_mode(input logic [3:0] code);
      mode_cfg_t cfg;
      cfg.dual = 1'b0;
      cfg.src  = TOP_FULL;
      case (code)
         4'd1:    begin cfg.dual = 1'b1; cfg.src = TOP_BYTE; end
         4'd3:    begin cfg.dual = 1'b1; cfg.src = TOP_TEN;  end
         4'd4:    cfg.src = TOP_CMP;
         4'd5:    cfg.src = TOP_BYTE;
         4'd7:    cfg.src = TOP_TEN;
         4'd10:   begin cfg.dual = 1'b1; cfg.src = TOP_CAP;  end
         4'd11:   begin cfg.dual = 1'b1; cfg.src = TOP_CMP;  end
         4'd12:   cfg.src = TOP_CAP;
         4'd14:   cfg.src = TOP_CAP;
         4'd15:   cfg.src = TOP_CMP;
         default: cfg.src = TOP_FULL;
      endcase
      return cfg;
   endfunction

endpackage

// File: rtl/wt_prescale.sv
module wt_prescale #(
   parameter int SEL_W    = 3,
   parameter int MAX_LOG2 = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SEL_W-1:0] sel,
   output logic             tick
);
   localparam int DIV_W  = MAX_LOG2;
   localparam int SPAN_W = DIV_W + 1;

   if (SEL_W < 3) begin : g_bad_sel
      $error("wt_prescale: SEL_W must be at least 3");
   end
   if (MAX_LOG2 < 10) begin : g_bad_div
      $error("wt_prescale: MAX_LOG2 must cover divide by 1024");
   end

   logic [SEL_W-1:0] sel_q;
   logic [DIV_W-1:0] pre_cnt;
   logic [DIV_W-1:0] term;
   logic [3:0]       sh;
   logic             en;
   logic             changed;

   always_comb begin
      en = 1'b1;
      case (sel)
         SEL_W'(1): sh = 4'd0;
         SEL_W'(2): sh = 4'd3;
         SEL_W'(3): sh = 4'd6;
         SEL_W'(4): sh = 4'd8;
         SEL_W'(5): sh = 4'd10;
         default:   begin sh = 4'd0; en = 1'b0; end
      endcase
      term = DIV_W'((SPAN_W'(1) << sh) - SPAN_W'(1));
   end

   assign changed = (sel != sel_q);
   assign tick    = en && !changed && (pre_cnt == term);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q   <= '0;
         pre_cnt <= '0;
      end else begin
         sel_q <= sel;
         if (changed || !en || tick) pre_cnt <= '0;
         else                        pre_cnt <= pre_cnt + 1'b1;
      end
   end
endmodule

// File: rtl/wt_mode_dec.sv
module wt_mode_dec
   import wave_timer_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic [3:0]       code,
   input  logic [CNT_W-1:0] cmp_a,
   input  logic [CNT_W-1:0] cap_val,
   output logic             dual,
   output logic [CNT_W-1:0] top
);
   localparam logic [CNT_W-1:0] TOP_B = CNT_W'(255);
   localparam logic [CNT_W-1:0] TOP_T = CNT_W'(1023);
   localparam logic [CNT_W-1:0] TOP_F = '1;

   mode_cfg_t cfg;

   always_comb begin
      cfg  = decode_mode(code);
      dual = cfg.dual;
      case (cfg.src)
         TOP_BYTE: top = TOP_B;
         TOP_TEN:  top = TOP_T;
         TOP_CMP:  top = cmp_a;
         TOP_CAP:  top = cap_val;
         default:  top = TOP_F;
      endcase
   end
endmodule

// File: rtl/wt_count_core.sv
module wt_count_core #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             dual,
   input  logic [CNT_W-1:0] top,
   output logic [CNT_W-1:0] count,
   output logic             down,
   output logic             top_hit,
   output logic             bottom_hit,
   output logic             wrap
);
   logic [CNT_W-1:0] nxt;
   logic             nxt_down;
   logic             reach_top;

   always_comb begin
      nxt      = count;
      nxt_down = down;
      if (tick) begin
         if (top == '0) begin
            nxt      = '0;
            nxt_down = 1'b0;
         end else if (!dual) begin
            nxt_down = 1'b0;
            nxt      = (count >= top) ? '0 : count + 1'b1;
         end else if (!down) begin
            if (count >= top) begin
               nxt      = count - 1'b1;
               nxt_down = 1'b1;
            end else begin
               nxt = count + 1'b1;
            end
         end else if (count == '0) begin
            nxt      = CNT_W'(1);
            nxt_down = 1'b0;
         end else begin
            nxt = count - 1'b1;
         end
      end
   end

   assign reach_top = tick && (nxt == top) && (count != top);
   assign wrap      = tick && (nxt == '0) && (count != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count      <= '0;
         down       <= 1'b0;
         top_hit    <= 1'b0;
         bottom_hit <= 1'b0;
      end else begin
         count      <= nxt;
         down       <= nxt_down;
         top_hit    <= reach_top;
         bottom_hit <= wrap;
      end
   end
endmodule

// File: rtl/wave_timer16.sv
module wave_timer16 #(
   parameter int CNT_W    = 16,
   parameter int SEL_W    = 3,
   parameter int MAX_LOG2 = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SEL_W-1:0] clk_sel,
   input  logic [1:0]       mode_a,
   input  logic [1:0]       mode_b,
   input  logic [CNT_W-1:0] cmp_a,
   input  logic [CNT_W-1:0] cap_val,
   input  logic             ovf_clr,
   input  logic             ovf_ack,
   input  logic             ovf_ie,
   output logic [CNT_W-1:0] count,
   output logic             count_down,
   output logic             top_hit,
   output logic             bottom_hit,
   output logic             ovf_flag,
   output logic             ovf_irq
);
   if (CNT_W < 10) begin : g_bad_width
      $error("wave_timer16: CNT_W must hold the 10-bit TOP");
   end

   logic             tick;
   logic             dual;
   logic             wrap;
   logic [CNT_W-1:0] top_w;

   wt_prescale #(.SEL_W(SEL_W), .MAX_LOG2(MAX_LOG2)) u_pre (
      .clk  (clk),
      .rst_n(rst_n),
      .sel  (clk_sel),
      .tick (tick)
   );

   wt_mode_dec #(.CNT_W(CNT_W)) u_dec (
      .code   ({mode_b, mode_a}),
      .cmp_a  (cmp_a),
      .cap_val(cap_val),
      .dual   (dual),
      .top    (top_w)
   );

   wt_count_core #(.CNT_W(CNT_W)) u_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .dual      (dual),
      .top       (top_w),
      .count     (count),
      .down      (count_down),
      .top_hit   (top_hit),
      .bottom_hit(bottom_hit),
      .wrap      (wrap)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  ovf_flag <= 1'b0;
      else if (wrap)               ovf_flag <= 1'b1;
      else if (ovf_clr || ovf_ack) ovf_flag <= 1'b0;
   end

   assign ovf_irq = ovf_flag & ovf_ie;
endmodule

// File: rtl/wt_checker.sv
module wt_checker #(
   parameter int CNT_W = 16,
   parameter int SEL_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic [SEL_W-1:0] clk_sel,
   input logic [CNT_W-1:0] count,
   input logic [CNT_W-1:0] top_val,
   input logic             top_hit,
   input logic             bottom_hit,
   input logic             ovf_flag,
   input logic             ovf_clr,
   input logic             ovf_ack,
   input logic             ovf_irq
);
   assert_stop_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(clk_sel) == SEL_W'(0)) |-> $stable(count));

   assert_unit_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(count) |-> (count == CNT_W'($past(count) + 1'b1) ||
                           count == CNT_W'($past(count) - 1'b1) ||
                           count == '0));

   assert_top_value_R6: assert property (@(posedge clk) disable iff (!rst_n)
      top_hit |-> (count == $past(top_val)));

   assert_bottom_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      bottom_hit |-> (count == '0));

   assert_flag_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
      bottom_hit |-> ovf_flag);

   assert_flag_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ovf_flag) |-> $past(ovf_clr || ovf_ack));

   assert_irq_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_irq |-> ovf_flag);
endmodule

bind wave_timer16 wt_checker #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .clk_sel   (clk_sel),
   .count     (count),
   .top_val   (top_w),
   .top_hit   (top_hit),
   .bottom_hit(bottom_hit),
   .ovf_flag  (ovf_flag),
   .ovf_clr   (ovf_clr),
   .ovf_ack   (ovf_ack),
   .ovf_irq   (ovf_irq)
);

// File: tb/wave_timer16_test.sv
`timescale 1ns/1ps
module wave_timer16_test;
   logic        clk = 1'b0;
   logic        rst_n;
   logic [2:0]  clk_sel;
   logic [1:0]  mode_a, mode_b;
   logic [15:0] cmp_a, cap_val;
   logic        ovf_clr, ovf_ack, ovf_ie;
   logic [15:0] count;
   logic        count_down, top_hit, bottom_hit, ovf_flag, ovf_irq;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 0;

   always #5 clk = ~clk;

   wave_timer16 uut (
      .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .mode_a(mode_a), .mode_b(mode_b),
      .cmp_a(cmp_a), .cap_val(cap_val), .ovf_clr(ovf_clr), .ovf_ack(ovf_ack),
      .ovf_ie(ovf_ie), .count(count), .count_down(count_down), .top_hit(top_hit),
      .bottom_hit(bottom_hit), .ovf_flag(ovf_flag), .ovf_irq(ovf_irq)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic edges(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic set_mode(input int m);
      mode_a = 2'(m);
      mode_b = 2'(m >> 2);
   endtask

   task automatic do_reset();
      rst_n = 1'b0; clk_sel = 3'd0; set_mode(0);
      cmp_a = 16'd0; cap_val = 16'd0;
      ovf_clr = 1'b0; ovf_ack = 1'b0; ovf_ie = 1'b0;
      edges(2);
      rst_n = 1'b1;
      edges(1);
   endtask

   // Runs n divide-by-1 steps from zero and compares each cycle to the
   // sequence implied by TOP t and counting style.
   task automatic seq_check(input string req, input int t, input bit dual, input int n);
      for (int k = 1; k <= n; k++) begin
         int p, ph, e;
         bit d;
         edges(1);
         p = k - 1;
         if (!dual) begin
            e = p % (t + 1);
            d = 1'b0;
         end else begin
            ph = p % (2 * t);
            e  = (ph <= t) ? ph : 2 * t - ph;
            d  = (ph > t) || (ph == 0 && p > 0);
         end
         chk(req, "count", count, e);
         chk(req, "count_down", count_down, d);
         chk("R6", "top_hit", top_hit, (e == t));
         chk("R7", "bottom_hit", bottom_hit, (e == 0 && p > 0));
      end
   endtask

   task automatic t_reset();
      do_reset();
      chk("R11", "count", count, 0);
      chk("R11", "count_down", count_down, 0);
      chk("R11", "top_hit", top_hit, 0);
      chk("R11", "bottom_hit", bottom_hit, 0);
      chk("R11", "ovf_flag", ovf_flag, 0);
      chk("R11", "ovf_irq", ovf_irq, 0);
   endtask

   task automatic t_up_modes();
      do_reset(); set_mode(4); cmp_a = 16'd5; clk_sel = 3'd1;
      seq_check("R3", 5, 1'b0, 20);
      do_reset(); set_mode(12); cap_val = 16'd3; cmp_a = 16'd9; clk_sel = 3'd1;
      seq_check("R3", 3, 1'b0, 12);
      do_reset(); set_mode(0); cmp_a = 16'd3; clk_sel = 3'd1;
      edges(65536);
      chk("R3", "mode0 count at TOP", count, 16'hFFFF);
      chk("R6", "mode0 top_hit", top_hit, 1);
      edges(1);
      chk("R3", "mode0 wrap", count, 0);
      chk("R7", "mode0 bottom_hit", bottom_hit, 1);
      chk("R8", "mode0 ovf_flag", ovf_flag, 1);
   endtask

   task automatic t_single_slope();
      do_reset(); set_mode(5); clk_sel = 3'd1;
      edges(256);
      chk("R4", "mode5 at 255", count, 255);
      edges(1);
      chk("R4", "mode5 wrap", count, 0);
      do_reset(); set_mode(7); clk_sel = 3'd1;
      edges(1024);
      chk("R4", "mode7 at 1023", count, 1023);
      edges(1);
      chk("R4", "mode7 wrap", count, 0);
      do_reset(); set_mode(15); cmp_a = 16'd9; clk_sel = 3'd1;
      seq_check("R4", 9, 1'b0, 25);
      do_reset(); set_mode(14); cap_val = 16'd6; clk_sel = 3'd1;
      seq_check("R4", 6, 1'b0, 20);
   endtask

   task automatic t_dual_slope();
      do_reset(); set_mode(11); cmp_a = 16'd4; clk_sel = 3'd1;
      seq_check("R5", 4, 1'b1, 20);
      do_reset(); set_mode(10); cap_val = 16'd3; clk_sel = 3'd1;
      seq_check("R5", 3, 1'b1, 15);
      do_reset(); set_mode(1); clk_sel = 3'd1;
      edges(256);
      chk("R5", "mode1 peak", count, 255);
      chk("R5", "mode1 dir at peak", count_down, 0);
      edges(1);
      chk("R5", "mode1 after peak", count, 254);
      chk("R5", "mode1 falling", count_down, 1);
      edges(254);
      chk("R5", "mode1 bottom", count, 0);
      chk("R7", "mode1 bottom_hit", bottom_hit, 1);
      edges(1);
      chk("R5", "mode1 rising again", count, 1);
      chk("R5", "mode1 dir up", count_down, 0);
      do_reset(); set_mode(3); clk_sel = 3'd1;
      edges(1024);
      chk("R5", "mode3 peak", count, 1023);
      edges(1023);
      chk("R5", "mode3 bottom", count, 0);
   endtask

   task automatic t_unlisted();
      int codes[2] = '{9, 2};
      foreach (codes[i]) begin
         do_reset(); set_mode(codes[i]); cmp_a = 16'd3; cap_val = 16'd3; clk_sel = 3'd1;
         edges(301);
         chk("R10", "unlisted mode count", count, 300);
      end
   endtask

   task automatic t_prescale();
      int shs[4] = '{3, 6, 8, 10};
      foreach (shs[i]) begin
         int n;
         n = 1 << shs[i];
         do_reset();
         clk_sel = 3'(i + 2);
         edges(n);
         chk("R1", "before first step", count, 0);
         edges(1);
         chk("R1", "first step", count, 1);
         edges(n - 1);
         chk("R1", "between steps", count, 1);
         edges(1);
         chk("R1", "second step", count, 2);
      end
      clk_sel = 3'd0;
      edges(50);
      chk("R1", "stopped code 000", count, 2);
      clk_sel = 3'd6;
      edges(50);
      chk("R1", "stopped code 110", count, 2);
   endtask

   task automatic t_restart();
      do_reset(); clk_sel = 3'd2;
      edges(9);
      chk("R2", "div8 first step", count, 1);
      edges(3);
      clk_sel = 3'd3;
      edges(64);
      chk("R2", "no step before full div64 period", count, 1);
      edges(1);
      chk("R2", "step after full div64 period", count, 2);
   endtask

   task automatic t_flag();
      do_reset(); set_mode(4); cmp_a = 16'd3; clk_sel = 3'd1;
      edges(5);
      chk("R8", "flag set on wrap", ovf_flag, 1);
      chk("R9", "irq masked", ovf_irq, 0);
      ovf_ie = 1'b1; #1;
      chk("R9", "irq enabled", ovf_irq, 1);
      ovf_clr = 1'b1;
      edges(1);
      chk("R8", "flag cleared by write", ovf_flag, 0);
      chk("R9", "irq follows clear", ovf_irq, 0);
      ovf_clr = 1'b0;
      edges(2);
      chk("R8", "flag stays clear", ovf_flag, 0);
      ovf_clr = 1'b1;
      edges(1);
      chk("R8", "set wins over clear", ovf_flag, 1);
      chk("R7", "collision bottom_hit", bottom_hit, 1);
      ovf_clr = 1'b0;
      edges(1);
      chk("R8", "flag holds", ovf_flag, 1);
      ovf_ack = 1'b1;
      edges(1);
      chk("R8", "flag cleared by ack", ovf_flag, 0);
      ovf_ack = 1'b0;
   endtask

   task automatic t_lower_top();
      do_reset(); set_mode(4); cmp_a = 16'd100; clk_sel = 3'd1;
      edges(51);
      chk("R12", "count before lowering", count, 50);
      cmp_a = 16'd10;
      edges(1);
      chk("R12", "wrap above new TOP", count, 0);
      chk("R12", "bottom_hit", bottom_hit, 1);
      chk("R12", "ovf_flag", ovf_flag, 1);
   endtask

   initial begin
      #1_900_000;
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_up_modes();
      t_single_slope();
      t_dual_slope();
      t_unlisted();
      t_prescale();
      t_restart();
      t_flag();
      t_lower_top();
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule